// File: doc/BRIEF.md
# Dual-Channel Programmable Interval Timer

This block holds two identical countdown channels and one free-running time counter, all reached over a 32-bit word-only register bus. Each channel keeps a reload (divider) register and a control register. A control write carries an operation code (load, hold or run) and a tick-source code. A running channel counts its value down by one on each tick of its selected source. On each tick where the count becomes zero, the channel raises a one-cycle hit pulse for the interrupt logic. On the tick after that, it reloads from its divider register.

Each channel is a two-state machine. The states are CH_HOLD (stopped) and CH_RUN (counting). The run operation moves the machine from CH_HOLD to CH_RUN. The hold operation moves it from CH_RUN to CH_HOLD. The load operation copies the divider into the count and keeps the current state. The clocks themselves are outside the block: every tick source arrives as a single-cycle enable input. One further enable input, the reference tick, advances the time counter.

Reads are combinational from `rd_addr`. Writes are taken on the rising edge when `wr_en` is high.

Top module: `dual_interval_timer`

## Requirements
- R1: Address map, byte offsets on an 8-bit bus address. Channel 0 uses divider 0x00, count 0x04 and control 0x08. Channel 1 uses divider 0x10, count 0x14 and control 0x18. The time counter is at 0x38. Any other address reads as zero, and a write to any other address changes nothing. A write to one channel never affects the other channel.
- R2: A control word has two fields: bits [1:0] hold the operation code and bits [4:2] hold the source code. Reading the control offset returns the last accepted control word, zero-extended. Reading the divider offset returns the divider.
- R3: Operation code 0 (load) copies the divider into the count. It leaves the CH_HOLD/CH_RUN state unchanged.
- R4: Operation code 1 (hold) moves the channel to CH_HOLD. Operation code 2 (run) moves it to CH_RUN. In CH_HOLD the count never changes and no hit is produced.
- R5: A control write with operation code 3 is ignored. The count, the state and the stored control word all stay as they were.
- R6: Writing the divider alone leaves the count unchanged. A reload uses whatever divider value is held at the time of the reload.
- R7: A source code c in the range 4 to 7 selects tick input bit c-4. Any other source code selects no tick, so a running channel holds its count.
- R8: In CH_RUN, each selected tick works as follows. A non-zero count decrements by one. A zero count reloads from the divider. The result is one hit every divider+1 ticks.
- R9: The hit output carries one bit per channel: channel 0 drives bit 0 and channel 1 drives bit 1. A hit bit is high for exactly the one cycle after the tick edge at which that channel's count became zero. The count reads zero during that cycle.
- R10: The time counter increments by one on each cycle with `ref_tick` high, wrapping modulo 2^32. Otherwise it holds.
- R11: After reset, every count, divider, control word and the time counter read zero. Both channels are in CH_HOLD and the hit outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write byte address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Read byte address |
| rd_data | output | 32 | Read data (combinational) |
| tick_src | input | 4 | Tick enables for source codes 4..7 |
| ref_tick | input | 1 | Reference tick for the time counter |
| hit | output | 2 | Per-channel terminal-count pulse |

## Verification
The bench covers the following corner cases, and what a faulty design would show in each:
- A divider write while a channel runs. A design that reloads on that write would show the new value at once, instead of only at the next zero.
- A divider of zero. A design that raised a hit only on the 1-to-0 step would never pulse; the correct design pulses on every tick.
- An illegal operation code, and a load issued while running. Mishandling either would show up as a stopped, advanced or altered count read back through the bus.
- Tick inputs other than the selected one, and ticks after reset. A design with a wrong source index or a wrong reset state would move the count, or pulse the wrong hit bit.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 8;
    localparam int OP_W      = 2;
    localparam int SRC_W     = 3;
    localparam int CTRL_W    = OP_W + SRC_W;
    localparam int NUM_SRC   = 4;
    localparam int SRC_BASE  = 4;
    localparam int CH_STRIDE = 16;
    localparam int OFF_DIV   = 0;
    localparam int OFF_CNT   = 4;
    localparam int OFF_CTRL  = 8;
    localparam int OFF_TIME  = 56;

    localparam logic [OP_W-1:0] OP_LOAD = 2'd0;
    localparam logic [OP_W-1:0] OP_HOLD = 2'd1;
    localparam logic [OP_W-1:0] OP_RUN  = 2'd2;
    localparam logic [OP_W-1:0] OP_BAD  = 2'd3;

    typedef enum logic {
        CH_HOLD = 1'b0,
        CH_RUN  = 1'b1
    } ch_state_e;
endpackage

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W = DATA_W,
    parameter int NSRC  = NUM_SRC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              div_wr,
    input  logic              ctrl_wr,
    input  logic [CNT_W-1:0]  div_in,
    input  logic [CTRL_W-1:0] ctrl_in,
    input  logic [NSRC-1:0]   tick_src,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [CNT_W-1:0]  div_o,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic              hit_o
);
    ch_state_e         state_q, state_n;
    logic [CNT_W-1:0]  cnt_q, cnt_n, cnt_step;
    logic [CNT_W-1:0]  div_q;
    logic [CTRL_W-1:0] ctrl_q, ctrl_n;
    logic              hit_q, hit_n;
    logic              tick_sel;
    logic [SRC_W-1:0]  src_q;
    logic [OP_W-1:0]   op_in;

    assign src_q = ctrl_q[CTRL_W-1:OP_W];
    assign op_in = ctrl_in[OP_W-1:0];

    // Source selection: code SRC_BASE+i picks tick_src[i]
    always_comb begin
        tick_sel = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (src_q == SRC_W'(SRC_BASE + i)) tick_sel = tick_src[i];
        end
    end

    assign cnt_step = (cnt_q == '0) ? div_q : cnt_q - 1'b1;

    // Divider register
    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else if (div_wr) div_q <= div_in;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CH_HOLD;
            cnt_q   <= '0;
            ctrl_q  <= '0;
            hit_q   <= 1'b0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
            ctrl_q  <= ctrl_n;
            hit_q   <= hit_n;
        end
    end

    // Next state and outputs; control write wins over a tick
    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        ctrl_n  = ctrl_q;
        hit_n   = 1'b0;
        if (ctrl_wr) begin
            if (op_in != OP_BAD) begin
                ctrl_n = ctrl_in;
                case (op_in)
                    OP_LOAD: cnt_n   = div_q;
                    OP_HOLD: state_n = CH_HOLD;
                    OP_RUN:  state_n = CH_RUN;
                    default: ;
                endcase
            end
        end else begin
            unique case (state_q)
                CH_HOLD: ;
                CH_RUN: begin
                    if (tick_sel) begin
                        cnt_n = cnt_step;
                        hit_n = (cnt_step == '0);
                    end
                end
            endcase
        end
    end

    assign cnt_o  = cnt_q;
    assign div_o  = div_q;
    assign ctrl_o = ctrl_q;
    assign hit_o  = hit_q;

    a_r3_load_value: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && op_in == OP_LOAD) |=> (cnt_q == $past(div_q)));

    a_r4_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_HOLD && !ctrl_wr) |=> ($stable(cnt_q) && !hit_q));

    a_r5_illegal_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && op_in == OP_BAD) |=> ($stable(cnt_q) && $stable(state_q) && $stable(ctrl_q)));

    a_r7_no_tick_no_move: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_wr && !tick_sel) |=> $stable(cnt_q));

    a_r9_hit_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        hit_q |-> (cnt_q == '0));
endmodule

// File: rtl/tmr_freerun.sv
module tmr_freerun
    import tmr_pkg::*;
#(
    parameter int TIME_W = DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    output logic [TIME_W-1:0] time_o
);
    logic [TIME_W-1:0] time_q;

    always_ff @(posedge clk) begin
        if (!rst_n) time_q <= '0;
        else if (ref_tick) time_q <= time_q + 1'b1;
    end

    assign time_o = time_q;

    a_r10_time_step: assert property (@(posedge clk) disable iff (!rst_n)
        ref_tick |=> (time_q == $past(time_q) + 1'b1));

    a_r10_time_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_tick |=> $stable(time_q));
endmodule

// File: rtl/tmr_regmap.sv
module tmr_regmap
    import tmr_pkg::*;
#(
    parameter int NCH = 2
) (
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [ADDR_W-1:0]            rd_addr,
    input  logic [NCH-1:0][DATA_W-1:0]   cnt_v,
    input  logic [NCH-1:0][DATA_W-1:0]   div_v,
    input  logic [NCH-1:0][CTRL_W-1:0]   ctrl_v,
    input  logic [DATA_W-1:0]            time_v,
    output logic [NCH-1:0]               div_wr,
    output logic [NCH-1:0]               ctrl_wr,
    output logic [DATA_W-1:0]            rd_data
);
    localparam logic [ADDR_W-1:0] A_TIME = ADDR_W'(OFF_TIME);

    for (genvar g = 0; g < NCH; g++) begin : g_wdec
        localparam logic [ADDR_W-1:0] A_DIV  = ADDR_W'(g * CH_STRIDE + OFF_DIV);
        localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(g * CH_STRIDE + OFF_CTRL);
        assign div_wr[g]  = wr_en && (wr_addr == A_DIV);
        assign ctrl_wr[g] = wr_en && (wr_addr == A_CTRL);
    end

    always_comb begin
        rd_data = '0;
        for (int c = 0; c < NCH; c++) begin
            if (rd_addr == ADDR_W'(c * CH_STRIDE + OFF_DIV))  rd_data = div_v[c];
            if (rd_addr == ADDR_W'(c * CH_STRIDE + OFF_CNT))  rd_data = cnt_v[c];
            if (rd_addr == ADDR_W'(c * CH_STRIDE + OFF_CTRL))
                rd_data = {{(DATA_W-CTRL_W){1'b0}}, ctrl_v[c]};
        end
        if (rd_addr == A_TIME) rd_data = time_v;
    end
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
    import tmr_pkg::*;
#(
    parameter int NCH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [NUM_SRC-1:0] tick_src,
    input  logic              ref_tick,
    output logic [NCH-1:0]    hit
);
    logic [NCH-1:0][DATA_W-1:0] cnt_v;
    logic [NCH-1:0][DATA_W-1:0] div_v;
    logic [NCH-1:0][CTRL_W-1:0] ctrl_v;
    logic [NCH-1:0]             div_wr;
    logic [NCH-1:0]             ctrl_wr;
    logic [DATA_W-1:0]          time_v;

    tmr_regmap #(.NCH(NCH)) u_map (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .rd_addr (rd_addr),
        .cnt_v   (cnt_v),
        .div_v   (div_v),
        .ctrl_v  (ctrl_v),
        .time_v  (time_v),
        .div_wr  (div_wr),
        .ctrl_wr (ctrl_wr),
        .rd_data (rd_data)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        tmr_channel #(.CNT_W(DATA_W), .NSRC(NUM_SRC)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .div_wr   (div_wr[g]),
            .ctrl_wr  (ctrl_wr[g]),
            .div_in   (wr_data),
            .ctrl_in  (wr_data[CTRL_W-1:0]),
            .tick_src (tick_src),
            .cnt_o    (cnt_v[g]),
            .div_o    (div_v[g]),
            .ctrl_o   (ctrl_v[g]),
            .hit_o    (hit[g])
        );
    end

    tmr_freerun #(.TIME_W(DATA_W)) u_time (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_tick (ref_tick),
        .time_o   (time_v)
    );

    a_r1_one_write_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({div_wr, ctrl_wr}));
endmodule

// File: tb/sim_dual_interval_timer.sv
module sim_dual_interval_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [3:0]  tick_src = '0;
    logic        ref_tick = 1'b0;
    logic [1:0]  hit;

    int checks = 0;
    int failures = 0;
    int hc0 = 0;
    int hc1 = 0;
    int hit_zero_bad = 0;

    always #5 clk = ~clk;

    dual_interval_timer u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .tick_src(tick_src), .ref_tick(ref_tick), .hit(hit)
    );

    // {write addr, write data, tick cycles (all sources), read addr, expected, req id}
    localparam int NV = 17;
    localparam logic [95:0] VEC [NV] = '{
        {8'h00, 32'd5,     8'd0, 8'h04, 32'd0,     8'd6},  // R6 divider alone
        {8'h08, 32'h10,    8'd0, 8'h04, 32'd5,     8'd3},  // R3 load
        {8'h08, 32'h12,    8'd3, 8'h04, 32'd2,     8'd8},  // R8 run
        {8'h08, 32'h11,    8'd4, 8'h04, 32'd2,     8'd4},  // R4 hold
        {8'h08, 32'h13,    8'd2, 8'h04, 32'd2,     8'd5},  // R5 illegal op
        {8'h30, 32'hff,    8'd0, 8'h08, 32'h11,    8'd5},  // R5 ctrl kept, R1 unmapped write
        {8'h08, 32'h12,    8'd2, 8'h04, 32'd0,     8'd8},  // R8 reach zero
        {8'h00, 32'd7,     8'd1, 8'h04, 32'd7,     8'd6},  // R6 reload takes new divider
        {8'h08, 32'h02,    8'd3, 8'h04, 32'd7,     8'd7},  // R7 source code 0
        {8'h08, 32'h1e,    8'd3, 8'h04, 32'd4,     8'd7},  // R7 source code 7
        {8'h10, 32'd3,     8'd0, 8'h14, 32'd0,     8'd6},  // R6 ch1 divider alone
        {8'h18, 32'h10,    8'd0, 8'h14, 32'd3,     8'd3},  // R3 ch1 load
        {8'h18, 32'h16,    8'd2, 8'h14, 32'd1,     8'd8},  // R8 ch1 run
        {8'h30, 32'd0,     8'd0, 8'h04, 32'd2,     8'd1},  // R1 ch0 separate
        {8'h30, 32'd0,     8'd0, 8'h10, 32'd3,     8'd2},  // R2 divider readback
        {8'h30, 32'd0,     8'd0, 8'h18, 32'h16,    8'd2},  // R2 ctrl readback
        {8'h30, 32'd0,     8'd0, 8'h3c, 32'd0,     8'd1}   // R1 unmapped read
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic sample_hits();
        if (hit[0]) begin
            hc0++;
            if (rd_addr == 8'h04 && rd_data != 32'd0) hit_zero_bad++;
        end
        if (hit[1]) hc1++;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        rd_addr = a;
        #1;
        chk(req, rd_data, exp);
    endtask

    task automatic ticks(input logic [3:0] m, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            sample_hits();
            tick_src = m;
        end
        @(negedge clk);
        sample_hits();
        tick_src = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        do_reset();
        // R11 reset state
        rd_chk("R11", 8'h04, 0);
        rd_chk("R11", 8'h08, 0);
        rd_chk("R11", 8'h14, 0);
        rd_chk("R11", 8'h38, 0);
        chk("R11", {30'd0, hit}, 0);

        for (int v = 0; v < NV; v++) begin
            logic [95:0] e;
            e = VEC[v];
            wr(e[95:88], e[87:56]);
            if (e[55:48] != 0) ticks(4'hf, int'(e[55:48]));
            rd_chk($sformatf("R%0d", e[7:0]), e[47:40], e[39:8]);
        end

        // R7 only the selected tick input moves a channel (ch0 src7, ch1 src5)
        ticks(4'b0001, 2);
        rd_chk("R7", 8'h14, 1);
        rd_chk("R7", 8'h04, 2);
        ticks(4'b1000, 1);
        rd_chk("R7", 8'h04, 1);
        rd_chk("R7", 8'h14, 1);

        // R11 channels stopped after reset
        do_reset();
        hc0 = 0; hc1 = 0;
        ticks(4'hf, 3);
        rd_chk("R11", 8'h04, 0);
        chk("R11", hc0 + hc1, 0);

        // R9 hit period div+1 on bit 0 only, count zero during hit
        wr(8'h00, 2);
        wr(8'h08, 32'h10);
        wr(8'h08, 32'h12);
        rd_addr = 8'h04;
        hc0 = 0; hc1 = 0; hit_zero_bad = 0;
        ticks(4'b0001, 6);
        chk("R9", hc0, 2);
        chk("R9", hc1, 0);
        chk("R9", hit_zero_bad, 0);

        // R8 divider zero: hit on every tick; R3 load keeps the run state
        wr(8'h00, 0);
        wr(8'h08, 32'h10);
        hc0 = 0;
        ticks(4'b0001, 4);
        chk("R8", hc0, 4);

        // R9 channel 1 drives bit 1
        wr(8'h10, 1);
        wr(8'h18, 32'h18);
        wr(8'h18, 32'h1a);
        hc0 = 0; hc1 = 0;
        ticks(4'b0100, 4);
        chk("R9", hc1, 2);
        chk("R9", hc0, 0);

        // R10 time counter
        rd_chk("R10", 8'h38, 0);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); ref_tick = 1'b1;
            @(negedge clk); ref_tick = 1'b0;
        end
        rd_chk("R10", 8'h38, 5);
        repeat (3) @(negedge clk);
        rd_chk("R10", 8'h38, 5);

        // R11 reset in the middle of a run
        do_reset();
        hc0 = 0; hc1 = 0;
        ticks(4'hf, 4);
        rd_chk("R11", 8'h14, 0);
        rd_chk("R11", 8'h18, 0);
        chk("R11", hc0 + hc1, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule